// File: doc/BRIEF.md
# Event Frame Serializer

This block drains captured detector events from a show-ahead readout FIFO and transmits each one as a fixed-length frame on a dedicated serial data line. An event is a 30-bit timestamp together with a 64-channel hit pattern, 94 bits in all. The line is driven from a fast core clock. A bit-rate enable, produced inside the block, divides that clock down to the serial rate. With a 500 MHz core clock and a divide of 5, the line runs at 100 Mbit/s, so one event takes a little under a microsecond.

The receiver locates each frame by a single start bit of 1 that comes in front of the 94 payload bits. The line rests at 0 whenever nothing is being sent. The FIFO entry is latched at frame start and popped only once its final payload bit has finished on the line. A busy output covers the whole frame. Identifying the chip and driving the physical link are left to later stages.

Top module: `evt_frame_ser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ser_dout`, `busy` and `fifo_rd` are 0, and `ser_ce` is 0 during reset.
- R2: `ser_ce` is a one-cycle pulse that repeats every BIT_DIV core cycles (default 5).
- R3: While no frame is in progress, the line `ser_dout` is held at 0 and `busy` is 0, including the whole time the FIFO stays empty.
- R4: A frame consists of a start bit of 1, then `fifo_rdata[93:64]` (timestamp) from bit 93 down to bit 64, then `fifo_rdata[63:0]` (hit bit i = channel i) from channel 63 down to channel 0: 95 bit periods in total.
- R5: `ser_dout` changes only in the cycle that follows a `ser_ce` pulse, so each bit is held for exactly one bit period.
- R6: `fifo_rd` is a one-cycle pulse, issued once per frame and never when `fifo_empty` is 1. It comes on the `ser_ce` edge that ends the last payload bit, so an entry is never removed before its last bit has been sent.
- R7: `busy` is 1 for exactly the bit periods from the start bit through the last payload bit.
- R8: Consecutive frames are separated by at least one idle 0 bit. When entries are waiting, one start bit follows the previous one after exactly 96 bit periods.
- R9: The frame content is latched when the start bit is launched. Changes on `fifo_rdata` during the frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (fast clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | Readout FIFO holds no entry |
| fifo_rdata | input | 94 | Head entry of the FIFO (show-ahead): {timestamp[29:0], hits[63:0]} |
| fifo_rd | output | 1 | Pop strobe for the FIFO head entry |
| ser_ce | output | 1 | Bit-rate enable, one pulse per serial bit period |
| ser_dout | output | 1 | Serial data line |
| busy | output | 1 | High while a frame is on the line |

## Verification
Every output is registered behind the `ser_ce` pulse. A new line bit, the rise or fall of `busy`, and the pop strobe therefore all take effect on the core clock edge that carries the enable, and each one stays as it is until the next enable. The bench works as a receiver. At the falling clock edge of each enable cycle it samples the bit that has just finished its period, and checks `busy` against the same period. It checks the pop strobe at the falling edge of the enable cycle that ends the last payload bit, 95 bit periods after that frame's start was launched. A waiting event's start bit is due exactly 96 bit periods after the previous one, and the bench checks that spacing on the same sampling grid.

// File: rtl/efs_pkg.sv
package efs_pkg;
   typedef enum logic [0:0] {
      EFS_IDLE = 1'b0,
      EFS_SEND = 1'b1
   } efs_state_e;
endpackage

// File: rtl/efs_tick_gen.sv
module efs_tick_gen #(
   parameter int unsigned DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("efs_tick_gen: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_full_rate
         logic run_q;
         always_ff @(posedge clk) begin
            if (!rst_n) run_q <= 1'b0;
            else        run_q <= 1'b1;
         end
         assign tick = run_q;
      end else begin : g_divided
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] TOP = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q <= '0;
            else if (cnt_q == TOP) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == TOP);

         // R2: enable is a single-cycle pulse
         a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
         // R2: pulse never occurs in the cycle just after reset
         a_r2_not_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> !tick);
      end
   endgenerate
endmodule

// File: rtl/efs_shifter.sv
module efs_shifter #(
   parameter int unsigned W = 94
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         dout,
   output logic         last
);
   localparam int unsigned LW = $clog2(W + 1);
   localparam logic [LW-1:0] FULL = LW'(W);

   logic [W-1:0]  sreg_q;
   logic [LW-1:0] left_q;
   logic          dout_q;

   generate
      if (W < 2) begin : g_bad_w
         $error("efs_shifter: payload width must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg_q <= '0;
         left_q <= '0;
         dout_q <= 1'b0;
      end else if (load) begin
         sreg_q <= din;
         left_q <= FULL;
         dout_q <= 1'b1;
      end else if (shift) begin
         if (left_q != '0) begin
            dout_q <= sreg_q[W-1];
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
         end else begin
            dout_q <= 1'b0;
         end
      end
   end

   assign dout = dout_q;
   assign last = (left_q == '0);

   // R8: a start bit is only launched from an idle (low) line
   a_r8_load_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !dout_q);
   // R5: the line never changes without a load or shift request
   a_r5_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) && !$past(shift) |-> $stable(dout_q));
endmodule

// File: rtl/efs_ctrl.sv
module efs_ctrl
   import efs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fifo_empty,
   input  logic last,
   output logic load,
   output logic shift,
   output logic pop,
   output logic busy
);
   efs_state_e st_q;
   logic       busy_q;

   always_comb begin
      load  = tick && (st_q == EFS_IDLE) && !fifo_empty;
      shift = tick && (st_q == EFS_SEND);
      pop   = shift && last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= EFS_IDLE;
         busy_q <= 1'b0;
      end else begin
         unique case (st_q)
            EFS_IDLE: if (load) begin
               st_q   <= EFS_SEND;
               busy_q <= 1'b1;
            end
            EFS_SEND: if (pop) begin
               st_q   <= EFS_IDLE;
               busy_q <= 1'b0;
            end
            default: st_q <= EFS_IDLE;
         endcase
      end
   end

   assign busy = busy_q;

   // R6: never pop an empty FIFO
   a_r6_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !fifo_empty);
   // R6: a pop always closes the frame
   a_r6_pop_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !busy_q);
   // R6: pop is a single-cycle strobe
   a_r6_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !pop);
endmodule

// File: rtl/evt_frame_ser.sv
module evt_frame_ser #(
   parameter int unsigned TS_W    = 30,
   parameter int unsigned HIT_W   = 64,
   parameter int unsigned BIT_DIV = 5,
   localparam int unsigned FW     = TS_W + HIT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_empty,
   input  logic [FW-1:0] fifo_rdata,
   output logic          fifo_rd,
   output logic          ser_ce,
   output logic          ser_dout,
   output logic          busy
);
   generate
      if (TS_W < 1)  begin : g_bad_ts  $error("evt_frame_ser: TS_W must be positive");  end
      if (HIT_W < 1) begin : g_bad_hit $error("evt_frame_ser: HIT_W must be positive"); end
   endgenerate

   logic tick, load, shift, pop, last, dout, busy_i;

   efs_tick_gen #(.DIV(BIT_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   efs_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .fifo_empty (fifo_empty),
      .last       (last),
      .load       (load),
      .shift      (shift),
      .pop        (pop),
      .busy       (busy_i)
   );

   efs_shifter #(.W(FW)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .shift (shift),
      .din   (fifo_rdata),
      .dout  (dout),
      .last  (last)
   );

   assign fifo_rd  = pop;
   assign ser_ce   = tick;
   assign ser_dout = dout;
   assign busy     = busy_i;

   // R3: idle line is low
   a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_dout);
   // R7: busy rises together with the start bit
   a_r7_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ser_dout);
   // R5: line only moves after an enable
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ser_ce) |-> $stable(ser_dout));
   // R6: pop coincides with an enable
   a_r6_pop_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> ser_ce);
   // R1: quiet outputs in the first cycle out of reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      $rose(rst_n) |-> !ser_dout && !busy && !fifo_rd);
endmodule

// File: tb/evt_frame_ser_tb.sv
module evt_frame_ser_tb;
   localparam int CLK_P = 10;
   localparam int FW    = 94;
   localparam int DIV   = 5;
   localparam int DEPTH = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fifo_empty;
   logic [FW-1:0] fifo_rdata;
   logic          fifo_rd, ser_ce, ser_dout, busy;

   logic [FW-1:0] mem [DEPTH];
   logic [FW-1:0] expq [256];
   int wr_ptr = 0, rd_ptr = 0, pushed = 0;
   int n_tests = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   assign fifo_empty = (rd_ptr == wr_ptr);
   assign fifo_rdata = mem[rd_ptr % DEPTH];

   evt_frame_ser u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
      .fifo_rd(fifo_rd), .ser_ce(ser_ce), .ser_dout(ser_dout), .busy(busy)
   );

   always @(posedge clk) if (fifo_rd) rd_ptr <= rd_ptr + 1;

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] mk(input logic [29:0] ts, input logic [63:0] hits);
      return {ts, hits};
   endfunction

   task automatic push(input logic [FW-1:0] v);
      mem[wr_ptr % DEPTH] = v;
      expq[pushed] = v;
      wr_ptr++;
      pushed++;
   endtask

   // receiver / monitor state
   bit            rx_on = 0;
   int            rx_cnt = 0, frames = 0, pops = 0, ce_idx = 0;
   int            gap = 0, last_start = -1000;
   bit            last_bit = 0, b2b = 0, seen_ce = 0;
   logic [FW-1:0] rx_frame;

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(!ser_dout && !busy && !fifo_rd && !ser_ce, "R1", {ser_dout, busy, fifo_rd, ser_ce}, 0);
         gap = 0;
      end else begin
         gap++;
         if (ser_ce) begin
            if (seen_ce) chk(gap == DIV, "R2", gap, DIV);
            seen_ce = 1;
            gap = 0;
            ce_idx++;
            if (!rx_on) begin
               if (ser_dout) begin
                  chk(busy, "R7", busy, 1);
                  chk(!last_bit, "R8", last_bit, 0);
                  if (b2b) chk(ce_idx - last_start == 96, "R8", ce_idx - last_start, 96);
                  b2b = 0;
                  last_start = ce_idx;
                  rx_on = 1;
                  rx_cnt = 0;
               end else begin
                  chk(!busy, "R3", busy, 0);
               end
            end else begin
               chk(busy, "R7", busy, 1);
               rx_frame[FW-1-rx_cnt] = ser_dout;
               rx_cnt++;
               if (rx_cnt == FW) begin
                  chk(rx_frame == expq[frames], "R4", rx_frame, expq[frames]);
                  frames++;
                  rx_on = 0;
               end
            end
            last_bit = ser_dout;
         end
         if (fifo_rd) begin
            chk(ser_ce && !rx_on && frames == pops + 1, "R6", {ser_ce, rx_on, frames}, {1'b1, 1'b0, pops + 1});
            chk(!fifo_empty, "R6", fifo_empty, 0);
            b2b = (wr_ptr - rd_ptr) > 1;
            pops++;
         end
      end
   end

   // R5: line changes only right after an enable
   logic ce_d = 0, dout_d = 0;
   always @(negedge clk) begin
      if (rst_n && !ce_d && ser_dout !== dout_d) chk(0, "R5", ser_dout, dout_d);
      ce_d = ser_ce;
      dout_d = ser_dout;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ser_dout && !busy && !fifo_rd, "R1", {ser_dout, busy, fifo_rd}, 0);
      // R3: empty FIFO, line idle
      repeat (300) @(negedge clk);
      chk(frames == 0 && pops == 0, "R3", frames, 0);
      // directed R4 patterns
      push(mk(30'h0, 64'h0));
      push(mk(30'h3FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF));
      push(mk(30'h2000_0001, 64'h8000_0000_0000_0001));
      push(mk(30'h1555_5555, 64'hAAAA_5555_F0F0_0F0F));
      wait (frames == pushed);
      repeat (50) @(negedge clk);
      // R9: disturb head entry while sent
      push(mk(30'h0ABC_DEF1, 64'h0123_4567_89AB_CDEF));
      wait (busy);
      repeat (200) @(negedge clk);
      mem[rd_ptr % DEPTH] = ~mem[rd_ptr % DEPTH];
      wait (frames == pushed);
      chk(1'b1, "R9", 0, 0);
      // random: bursts and gaps
      for (int i = 0; i < 14; i++) begin
         push({$urandom, $urandom, $urandom});
         if ($urandom % 3 == 0) repeat ($urandom % 900) @(negedge clk);
      end
      wait (frames == pushed);
      repeat (600) @(negedge clk);
      chk(pops == pushed && frames == pushed, "R6", pops, pushed);
      chk(!busy && !ser_dout, "R3", {busy, ser_dout}, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule